// File: doc/BRIEF.md
# UART Receive Byte Queue with Status Word

This block sits between the receive-side deserializer of a UART and the register file that software reads. Each byte the deserializer delivers is either stored in a circular queue of parameterised depth or, when queueing is switched off, kept in a single holding register. Software drains bytes by reading a data register. Several other registers report the fill level, a full flag, a sticky overflow flag, data-ready state, a break indication and an error interrupt source.

A line break seen by the deserializer appears in the queue as a null byte and is also latched as a break error. The break error clears when software reads the error register. A control write can empty the queue; the flush bit that requests this is never stored. The block also drives a DMA-busy output: it is high when the receive mode selects DMA and the queue holds nothing.

Register map (3-bit word address): 0 control (bit 0 queue enable, bit 1 flush command), 1 receive mode (bits 1:0), 2 line status (bit 0 data ready), 3 error status (bit 3 break), 4 fill status (bits 7:0 count, bit 8 full, bit 9 overflow error), 5 data (read pops), 6 interrupt source (bit 1 error, write 1 to clear). Read data is registered and appears the cycle after the read strobe.

Top module: `uart_rxq_top`

## Requirements
- R1: After reset the fill status, line status, error status, interrupt source and control registers read 0, and dma_busy is low.
- R2: With control bit 0 set, received bytes are returned by data reads in arrival order, and fill status bits 7:0 give the number of stored bytes.
- R3: Writing control with bit 1 set empties the queue (fill status 0, line status bit 0 cleared); control bit 1 always reads back 0.
- R4: A byte that arrives while the queue is full is dropped, and interrupt source bit 1 and fill status bit 9 are set. Bit 9 stays set until a flush.
- R5: A data read in queue mode while the queue is empty returns 0 and sets interrupt source bit 1.
- R6: A pulse on rx_break stores a 0x00 byte in the queue and sets error status bit 3.
- R7: Reading the error status register returns its value and then clears every bit of it.
- R8: When the queue holds DEPTH bytes, fill status bits 7:0 read 0 and bit 8 reads 1.
- R9: Line status bit 0 is set after a byte is queued and drops when a data read leaves the queue empty.
- R10: With control bit 0 clear, a received byte goes into a holding register and sets line status bit 0. A data read returns that byte and clears bit 0. The queue count is not changed.
- R11: dma_busy is high exactly when receive-mode bits 1:0 equal 2'b10 and the queue is empty.
- R12: Writing 1 to interrupt source bit 1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Deserializer byte strobe, one cycle per byte |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | One-cycle pulse on a detected line break |
| reg_we | input | 1 | Register write enable |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data, valid the cycle after reg_re |
| dma_busy | output | 1 | DMA receive mode with an empty queue |

## Verification
The assertions assume that rx_valid and rx_break are never high in the same cycle. They also assume that a flush write never coincides with a byte arrival or a data read, and that software does not change the queue-enable bit while data is pending. The bench drives every stimulus from sequential tasks, one action per cycle, so none of these overlaps can occur. Break pulses are issued only in queue mode. Expected bytes pass through a scoreboard queue that the bench fills from its own model of free space.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_MODE  = 3'd1,
    RA_LSTAT = 3'd2,
    RA_ERRST = 3'd3,
    RA_FSTAT = 3'd4,
    RA_DATA  = 3'd5,
    RA_ISRC  = 3'd6
  } rxq_addr_e;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_FLUSH_BIT = 1;
  localparam int ISRC_ERR_BIT   = 1;
  localparam int ERRST_BRK_BIT  = 3;
  localparam logic [1:0] MODE_DMA = 2'b10;

  // Fill status word: the count field is zeroed when full, the full flag takes its place.
  function automatic logic [31:0] fstat_word(input logic [7:0] cnt,
                                             input logic full,
                                             input logic err);
    return {22'b0, err, full, (full ? 8'h00 : cnt)};
  endfunction

  function automatic logic [31:0] errst_word(input logic brk);
    logic [31:0] w;
    w = '0;
    w[ERRST_BRK_BIT] = brk;
    return w;
  endfunction

  function automatic logic [31:0] isrc_word(input logic err);
    logic [31:0] w;
    w = '0;
    w[ISRC_ERR_BIT] = err;
    return w;
  endfunction

endpackage

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign dout    = mem[rptr_q];
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= ptr_inc(wptr_q);
      if (pop_ok)  rptr_q <= ptr_inc(rptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/uart_rxq_csr.sv
module uart_rxq_csr
  import uart_rxq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_break,
  input  logic [7:0]  q_count8,
  input  logic        q_one_left,
  input  logic        q_full,
  input  logic        q_empty,
  input  logic [7:0]  q_head,
  output logic        q_push,
  output logic        q_pop,
  output logic        q_flush,
  output logic [7:0]  q_din,
  output logic        fifo_en,
  output logic [1:0]  rx_mode,
  output logic        data_ready,
  output logic        err_src,
  output logic        brk_flag,
  output logic        data_rd,
  output logic        errst_rd,
  output logic        overflow_ev,
  output logic        underflow_ev
);

  logic        en_q;
  logic [1:0]  mode_q;
  logic        ready_q, err_q, brk_q, ovf_q;
  logic [7:0]  hold_q;
  logic [31:0] rdata_q, rd_mux;
  logic        wr_ctrl, wr_mode, wr_isrc;
  logic [29:0] unused_wbits;

  assign unused_wbits = reg_wdata[31:2];

  assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
  assign wr_mode = reg_we && (reg_addr == RA_MODE);
  assign wr_isrc = reg_we && (reg_addr == RA_ISRC);
  assign data_rd = reg_re && (reg_addr == RA_DATA);
  assign errst_rd = reg_re && (reg_addr == RA_ERRST);

  assign q_flush = wr_ctrl && reg_wdata[CTRL_FLUSH_BIT];
  assign q_pop   = data_rd && en_q;
  assign q_push  = (rx_valid && en_q) || rx_break;
  assign q_din   = rx_break ? 8'h00 : rx_data;

  assign overflow_ev  = q_push && q_full;
  assign underflow_ev = q_pop && q_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 2'b00;
    end else begin
      if (wr_ctrl) en_q   <= reg_wdata[CTRL_EN_BIT];
      if (wr_mode) mode_q <= reg_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q <= 1'b0;
      err_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (rx_break)      brk_q <= 1'b1;
      else if (errst_rd) brk_q <= 1'b0;
      if (overflow_ev || underflow_ev)         err_q <= 1'b1;
      else if (wr_isrc && reg_wdata[ISRC_ERR_BIT]) err_q <= 1'b0;
      if (q_flush)          ovf_q <= 1'b0;
      else if (overflow_ev) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      hold_q  <= 8'h00;
    end else if (en_q) begin
      if (q_flush)                                 ready_q <= 1'b0;
      else if (q_push && !q_full)                  ready_q <= 1'b1;
      else if (q_pop && !q_empty && q_one_left)    ready_q <= 1'b0;
    end else begin
      if (rx_valid) begin
        hold_q  <= rx_data;
        ready_q <= 1'b1;
      end else if (data_rd) begin
        ready_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_CTRL:  rd_mux[CTRL_EN_BIT] = en_q;
      RA_MODE:  rd_mux[1:0] = mode_q;
      RA_LSTAT: rd_mux[0] = ready_q;
      RA_ERRST: rd_mux = errst_word(brk_q);
      RA_FSTAT: rd_mux = fstat_word(q_count8, q_full, ovf_q);
      RA_DATA:  rd_mux[7:0] = en_q ? (q_empty ? 8'h00 : q_head) : hold_q;
      RA_ISRC:  rd_mux = isrc_word(err_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_re) rdata_q <= rd_mux;
  end

  assign reg_rdata  = rdata_q;
  assign fifo_en    = en_q;
  assign rx_mode    = mode_q;
  assign data_ready = ready_q;
  assign err_src    = err_q;
  assign brk_flag   = brk_q;

endmodule

// File: rtl/uart_rxq_top.sv
module uart_rxq_top
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_break,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        dma_busy
);

  logic          q_push, q_pop, q_flush, q_full, q_empty;
  logic [7:0]    q_din, q_head, q_count8;
  logic [CW-1:0] fill_cnt;
  logic          q_one_left;
  logic          fifo_en, data_ready, err_src, brk_flag;
  logic          data_rd, errst_rd, overflow_ev, underflow_ev;
  logic [1:0]    rx_mode;

  assign q_count8   = 8'(fill_cnt);
  assign q_one_left = (fill_cnt == CW'(1));

  uart_rxq_store #(.DEPTH(DEPTH), .DW(8)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .pop   (q_pop),
    .flush (q_flush),
    .din   (q_din),
    .dout  (q_head),
    .count (fill_cnt),
    .full  (q_full),
    .empty (q_empty)
  );

  uart_rxq_csr u_csr (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_re       (reg_re),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_break     (rx_break),
    .q_count8     (q_count8),
    .q_one_left   (q_one_left),
    .q_full       (q_full),
    .q_empty      (q_empty),
    .q_head       (q_head),
    .q_push       (q_push),
    .q_pop        (q_pop),
    .q_flush      (q_flush),
    .q_din        (q_din),
    .fifo_en      (fifo_en),
    .rx_mode      (rx_mode),
    .data_ready   (data_ready),
    .err_src      (err_src),
    .brk_flag     (brk_flag),
    .data_rd      (data_rd),
    .errst_rd     (errst_rd),
    .overflow_ev  (overflow_ev),
    .underflow_ev (underflow_ev)
  );

  assign dma_busy = (rx_mode == MODE_DMA) && q_empty;

endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          q_push,
  input logic          q_pop,
  input logic          q_flush,
  input logic          rx_break,
  input logic [CW-1:0] fill_cnt,
  input logic          data_rd,
  input logic          errst_rd,
  input logic          data_ready,
  input logic          err_src,
  input logic          brk_flag,
  input logic          dma_busy
);

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(DEPTH)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == CW'(DEPTH) && q_push && !q_pop && !q_flush) |=> (fill_cnt == CW'(DEPTH) && err_src)); // R4

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    q_flush |=> (fill_cnt == '0)); // R3

  AST_EMPTY_READ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && fifo_en && fill_cnt == '0) |=> err_src); // R5

  AST_BREAK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> brk_flag); // R6

  AST_ERRST_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (errst_rd && !rx_break) |=> !brk_flag); // R7

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && q_pop && !q_push && !q_flush && fill_cnt == CW'(1)) |=> !data_ready); // R9

  AST_DMA_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    dma_busy |-> (fill_cnt == '0)); // R11

endmodule

bind uart_rxq_top uart_rxq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_en    (fifo_en),
  .q_push     (q_push),
  .q_pop      (q_pop),
  .q_flush    (q_flush),
  .rx_break   (rx_break),
  .fill_cnt   (fill_cnt),
  .data_rd    (data_rd),
  .errst_rd   (errst_rd),
  .data_ready (data_ready),
  .err_src    (err_src),
  .brk_flag   (brk_flag),
  .dma_busy   (dma_busy)
);

// File: tb/uart_rxq_top_tb.sv
module uart_rxq_top_tb;

  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam logic [2:0] A_CTRL = 3'd0, A_MODE = 3'd1, A_LSTAT = 3'd2,
                         A_ERRST = 3'd3, A_FSTAT = 3'd4, A_DATA = 3'd5, A_ISRC = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dma_busy;

  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  bit   mon_en = 1'b0;
  bit   m_en = 1'b0;
  int   m_cnt = 0;
  string mon_tag = "";
  logic [7:0] exp_q [$];

  always #(CLK_P/2) clk = ~clk;

  uart_rxq_top #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_busy(dma_busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
    if (a == A_CTRL) begin
      if (d[1]) begin exp_q.delete(); m_cnt = 0; end
      m_en = d[0];
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    v = reg_rdata;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(v == exp, tag, v, exp);
  endtask

  // Driver: one byte per cycle; the scoreboard gets it only if the model says it fits.
  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
    if (m_en && m_cnt < DEPTH) begin exp_q.push_back(b); m_cnt++; end
  endtask

  task automatic brk();
    @(negedge clk);
    rx_break = 1'b1;
    @(negedge clk);
    rx_break = 1'b0;
    if (m_cnt < DEPTH) begin exp_q.push_back(8'h00); m_cnt++; end
  endtask

  task automatic pop_data(input string tag);
    logic [31:0] v;
    mon_tag = tag;
    mon_en = 1'b1;
    rd(A_DATA, v);
    mon_en = 1'b0;
    if (m_cnt > 0) m_cnt--;
  endtask

  // Monitor: compares each popped byte with the scoreboard head.
  always @(posedge clk) begin
    if (reg_re && reg_addr == A_DATA && mon_en) begin
      logic [7:0] e;
      #2;
      if (exp_q.size() == 0) begin
        chk(1'b0, {mon_tag, " scoreboard empty"}, reg_rdata, 32'h0);
      end else begin
        e = exp_q.pop_front();
        chk(reg_rdata == {24'h0, e}, mon_tag, reg_rdata, {24'h0, e});
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(dma_busy == 1'b0, "R1 dma_busy", {31'b0, dma_busy}, 32'h0);
    rd_chk(A_FSTAT, 32'h0, "R1 fill status");
    rd_chk(A_LSTAT, 32'h0, "R1 line status");
    rd_chk(A_ERRST, 32'h0, "R1 error status");
    rd_chk(A_ISRC,  32'h0, "R1 interrupt source");
    rd_chk(A_CTRL,  32'h0, "R1 control");

    // R2 / R9 ordered queue and data-ready
    wr(A_CTRL, 32'h1);
    send(8'h11); send(8'h22); send(8'h33);
    rd_chk(A_FSTAT, 32'h3, "R2 fill count");
    rd_chk(A_LSTAT, 32'h1, "R9 ready after push");
    pop_data("R2 first byte");
    pop_data("R2 second byte");
    rd_chk(A_LSTAT, 32'h1, "R9 ready with one left");
    pop_data("R2 third byte");
    rd_chk(A_LSTAT, 32'h0, "R9 ready dropped on empty");

    // R11 DMA busy
    wr(A_MODE, 32'h2);
    chk(dma_busy == 1'b1, "R11 busy when empty", {31'b0, dma_busy}, 32'h1);
    send(8'hA5);
    chk(dma_busy == 1'b0, "R11 idle with data", {31'b0, dma_busy}, 32'h0);
    pop_data("R11 drain");
    chk(dma_busy == 1'b1, "R11 busy again", {31'b0, dma_busy}, 32'h1);
    wr(A_MODE, 32'h1);
    chk(dma_busy == 1'b0, "R11 other mode", {31'b0, dma_busy}, 32'h0);
    wr(A_MODE, 32'h0);

    // R5 empty read, R12 clear
    rd_chk(A_DATA, 32'h0, "R5 empty read data");
    rd_chk(A_ISRC, 32'h2, "R5 error source set");
    wr(A_ISRC, 32'h2);
    rd_chk(A_ISRC, 32'h0, "R12 error source cleared");

    // R8 full, R4 overflow
    for (int i = 0; i < DEPTH; i++) send(8'(8'h40 + i));
    rd_chk(A_FSTAT, 32'h100, "R8 full word");
    send(8'hEE);
    rd_chk(A_FSTAT, 32'h300, "R4 overflow flag while full");
    rd_chk(A_ISRC, 32'h2, "R4 error source on overflow");
    for (int i = 0; i < DEPTH; i++) pop_data("R4 stored bytes only");
    rd_chk(A_FSTAT, 32'h200, "R4 overflow flag sticky");
    wr(A_ISRC, 32'h2);

    // R3 flush
    send(8'h01); send(8'h02);
    wr(A_CTRL, 32'h3);
    rd_chk(A_FSTAT, 32'h0, "R3 flush empties");
    rd_chk(A_LSTAT, 32'h0, "R3 ready cleared");
    rd_chk(A_CTRL, 32'h1, "R3 flush bit reads 0");

    // R6 break, R7 read-clear
    brk();
    rd_chk(A_FSTAT, 32'h1, "R6 null byte stored");
    rd_chk(A_ERRST, 32'h8, "R6 break bit");
    rd_chk(A_ERRST, 32'h0, "R7 cleared by read");
    pop_data("R6 null byte value");

    // R10 holding register
    wr(A_CTRL, 32'h0);
    send(8'h5A);
    rd_chk(A_LSTAT, 32'h1, "R10 ready in holding mode");
    rd_chk(A_FSTAT, 32'h0, "R10 queue untouched");
    rd_chk(A_DATA, 32'h5A, "R10 holding byte");
    rd_chk(A_LSTAT, 32'h0, "R10 ready cleared by read");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule